// File: doc/BRIEF.md
# S-bus activation controller

This block runs the layer-1 wake-up and shut-down handshake of a four-wire basic-rate subscriber bus. One parameter selects the end of the link it serves: the network end or the terminal end. The block does not touch the line itself. A framer and a receiver ahead of it reduce each frame period to one strobe, plus a classification of what arrived:
- an idle line;
- a wake-up tone;
- a framed signal, with flags for frame lock and for the received activation bit.

Local software-side requests to bring the link up or down arrive as levels, which are sampled on the same strobe.

From these inputs the block chooses the signal class that the transmitter sends next and the activation bit that goes into outgoing frames. It also reports whether the link is activated.

The network end answers a wake-up with framed signal that carries no payload and a cleared activation bit. It may also start this phase on its own. Once it locks to the terminal's framed reply, it sends payload frames with the activation bit set. The terminal end asks for service with a wake-up tone. When it locks to framed signal from the network, it answers with payload frames. It reports activated only once the received frames carry the activation bit.

Two guards return the block to idle:
- a run of idle frames while the link is up or being confirmed;
- an attempt that does not finish within a set number of frames.

Top module: `sbus_activation_ctrl`

## Requirements
- R1: While reset is held and right after it, tx_info is 0 (idle), tx_abit is 0 and activated is 0.
- R2: Network end, idle, receiving rx_class 1 (wake-up) on a frame strobe: tx_info becomes 2 (framed, no payload) with tx_abit 0.
- R3: Network end, idle, with act_req high on a frame strobe: tx_info becomes 2 directly, without any wake-up received.
- R4: Network end, sending class 2, receiving framed signal (rx_class 2 or 3) with rx_sync high on a strobe: tx_info becomes 3 (framed with payload), tx_abit 1 and activated 1.
- R5: Terminal end, idle, with act_req high on a strobe and no locked framed signal: tx_info becomes 1 (wake-up).
- R6: Terminal end, idle or sending wake-up, receiving framed signal with rx_sync high on a strobe: tx_info becomes 3 with tx_abit 0 and activated still 0.
- R7: Terminal end, sending class 3 but not activated, receiving locked framed signal with rx_abit high on a strobe: activated becomes 1.
- R8: When the link is up (either end) or the terminal is confirming, LOSS_FRAMES consecutive strobes with rx_class 0 return the block to idle (tx_info 0, activated 0) on the last of them.
- R9: A strobe with rx_class other than 0 restarts the idle-frame run, so interrupted idle runs never deactivate.
- R10: An activation attempt (network sending class 2, terminal sending class 1, or terminal sending class 3 before activation) returns to idle on the TIMEOUT_FRAMES-th strobe after entering that phase, unless it progresses first.
- R11: deact_req high on a strobe sends the block to idle from any state, ahead of every other condition, including a simultaneous act_req.
- R12: All inputs are acted on only in cycles where frame_tick is high. Outputs change only in the cycle after such a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe per frame period |
| rx_class | input | 2 | Received class: 0 idle, 1 wake-up, 2 or 3 framed |
| rx_sync | input | 1 | Frame lock to the received framed signal |
| rx_abit | input | 1 | Activation bit of the received frame |
| act_req | input | 1 | Local request to activate |
| deact_req | input | 1 | Local request to deactivate |
| tx_info | output | 2 | Class to send: 0 idle, 1 wake-up, 2 framed no payload, 3 framed payload |
| tx_abit | output | 1 | Activation bit for outgoing frames |
| activated | output | 1 | Link activated |

## Verification
The bench builds two instances side by side from the same stimulus: one with IS_NETWORK=1 and one with IS_NETWORK=0. Both use LOSS_FRAMES=3 and TIMEOUT_FRAMES=4. These small limits bring every expiry within a handful of frames: attempts timing out in each pending phase, and idle runs that are cut one frame short of deactivation. Frame strobes come every fourth cycle. Activate and deactivate requests are driven high in the cycles between strobes, which exposes any state change taken off the strobe.

// File: rtl/sbus_act_pkg.sv
package sbus_act_pkg;

   typedef enum logic [1:0] {
      TXC_IDLE     = 2'd0,
      TXC_WAKE     = 2'd1,
      TXC_ANNOUNCE = 2'd2,
      TXC_PAYLOAD  = 2'd3
   } txc_e;

   typedef struct packed {
      logic idle;
      logic wake;
      logic framed;
      logic lock;
      logic abit;
      logic act;
      logic deact;
   } frame_ind_t;

   typedef struct packed {
      txc_e tx;
      logic abit;
      logic activated;
      logic pending;
      logic monitored;
   } ctl_out_t;

   function automatic frame_ind_t decode_ind(input logic [1:0] rx,
                                             input logic sync,
                                             input logic abit,
                                             input logic act,
                                             input logic deact);
      frame_ind_t f;
      f.idle   = (rx == 2'd0);
      f.wake   = (rx == 2'd1);
      f.framed = rx[1];
      f.lock   = rx[1] & sync;
      f.abit   = abit;
      f.act    = act;
      f.deact  = deact;
      return f;
   endfunction

endpackage

// File: rtl/sbus_frame_run.sv
module sbus_frame_run #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic restart,
   input  logic tick,
   input  logic hit,
   output logic reached
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!enable || restart) begin
         cnt <= '0;
      end else if (tick) begin
         if (!hit)
            cnt <= '0;
         else if (cnt != LAST)
            cnt <= cnt + 1'b1;
      end
   end

   assign reached = enable & tick & hit & (cnt == LAST);

endmodule

// File: rtl/sbus_net_seq.sv
module sbus_net_seq
   import sbus_act_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_ind_t ind,
   input  logic       lost,
   input  logic       expired,
   output ctl_out_t   ctl,
   output logic       moved
);
   typedef enum logic [1:0] {NS_QUIET, NS_OFFER, NS_LIVE} net_st_e;

   net_st_e st, nxt;
   logic    unused_ind;

   assign unused_ind = ind.abit ^ ind.framed ^ ind.idle;

   always_comb begin
      nxt = st;
      if (ind.deact) begin
         nxt = NS_QUIET;
      end else begin
         unique case (st)
            NS_QUIET: if (ind.act || ind.wake) nxt = NS_OFFER;
            NS_OFFER: begin
               if (ind.lock)   nxt = NS_LIVE;
               else if (expired) nxt = NS_QUIET;
            end
            NS_LIVE:  if (lost) nxt = NS_QUIET;
            default:  nxt = NS_QUIET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= NS_QUIET;
      else if (tick) st <= nxt;
   end

   assign moved = tick & (nxt != st);

   always_comb begin
      ctl = '0;
      unique case (st)
         NS_OFFER: begin
            ctl.tx      = TXC_ANNOUNCE;
            ctl.pending = 1'b1;
         end
         NS_LIVE: begin
            ctl.tx        = TXC_PAYLOAD;
            ctl.abit      = 1'b1;
            ctl.activated = 1'b1;
            ctl.monitored = 1'b1;
         end
         default: ctl.tx = TXC_IDLE;
      endcase
   end

endmodule

// File: rtl/sbus_term_seq.sv
module sbus_term_seq
   import sbus_act_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_ind_t ind,
   input  logic       lost,
   input  logic       expired,
   output ctl_out_t   ctl,
   output logic       moved
);
   typedef enum logic [1:0] {TS_QUIET, TS_CALL, TS_ANSWER, TS_LIVE} term_st_e;

   term_st_e st, nxt;
   logic     unused_ind;

   assign unused_ind = ind.wake ^ ind.framed ^ ind.idle;

   always_comb begin
      nxt = st;
      if (ind.deact) begin
         nxt = TS_QUIET;
      end else begin
         unique case (st)
            TS_QUIET: begin
               if (ind.lock)     nxt = TS_ANSWER;
               else if (ind.act) nxt = TS_CALL;
            end
            TS_CALL: begin
               if (ind.lock)     nxt = TS_ANSWER;
               else if (expired) nxt = TS_QUIET;
            end
            TS_ANSWER: begin
               if (ind.lock && ind.abit) nxt = TS_LIVE;
               else if (lost || expired) nxt = TS_QUIET;
            end
            TS_LIVE: if (lost) nxt = TS_QUIET;
            default: nxt = TS_QUIET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= TS_QUIET;
      else if (tick) st <= nxt;
   end

   assign moved = tick & (nxt != st);

   always_comb begin
      ctl = '0;
      unique case (st)
         TS_CALL: begin
            ctl.tx      = TXC_WAKE;
            ctl.pending = 1'b1;
         end
         TS_ANSWER: begin
            ctl.tx        = TXC_PAYLOAD;
            ctl.pending   = 1'b1;
            ctl.monitored = 1'b1;
         end
         TS_LIVE: begin
            ctl.tx        = TXC_PAYLOAD;
            ctl.activated = 1'b1;
            ctl.monitored = 1'b1;
         end
         default: ctl.tx = TXC_IDLE;
      endcase
   end

endmodule

// File: rtl/sbus_activation_ctrl.sv
module sbus_activation_ctrl
   import sbus_act_pkg::*;
#(
   parameter bit IS_NETWORK     = 1'b1,
   parameter int LOSS_FRAMES    = 8,
   parameter int TIMEOUT_FRAMES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_tick,
   input  logic [1:0] rx_class,
   input  logic       rx_sync,
   input  logic       rx_abit,
   input  logic       act_req,
   input  logic       deact_req,
   output logic [1:0] tx_info,
   output logic       tx_abit,
   output logic       activated
);
   if (LOSS_FRAMES < 1) begin : g_bad_loss
      $error("LOSS_FRAMES must be at least 1");
   end
   if (TIMEOUT_FRAMES < 1) begin : g_bad_timeout
      $error("TIMEOUT_FRAMES must be at least 1");
   end

   frame_ind_t ind;
   ctl_out_t   ctl;
   logic       moved;
   logic       lost;
   logic       expired;

   assign ind = decode_ind(rx_class, rx_sync, rx_abit, act_req, deact_req);

   sbus_frame_run #(.LIMIT(LOSS_FRAMES)) u_idle_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctl.monitored),
      .restart (moved),
      .tick    (frame_tick),
      .hit     (ind.idle),
      .reached (lost)
   );

   sbus_frame_run #(.LIMIT(TIMEOUT_FRAMES)) u_attempt_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctl.pending),
      .restart (moved),
      .tick    (frame_tick),
      .hit     (1'b1),
      .reached (expired)
   );

   if (IS_NETWORK) begin : g_net
      sbus_net_seq u_seq (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (frame_tick),
         .ind     (ind),
         .lost    (lost),
         .expired (expired),
         .ctl     (ctl),
         .moved   (moved)
      );
   end else begin : g_term
      sbus_term_seq u_seq (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (frame_tick),
         .ind     (ind),
         .lost    (lost),
         .expired (expired),
         .ctl     (ctl),
         .moved   (moved)
      );
   end

   assign tx_info   = ctl.tx;
   assign tx_abit   = ctl.abit;
   assign activated = ctl.activated;

endmodule

// File: rtl/sbus_activation_props.sv
module sbus_activation_props #(
   parameter bit IS_NET = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_tick,
   input logic [1:0] rx_class,
   input logic       rx_sync,
   input logic       rx_abit,
   input logic       deact_req,
   input logic [1:0] tx_info,
   input logic       tx_abit,
   input logic       activated
);

   p_hold_off_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> ($stable(tx_info) && $stable(activated) && $stable(tx_abit)));

   p_deact_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && deact_req) |=> (tx_info == 2'd0 && !activated && !tx_abit));

   p_rise_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(activated) |-> $past(frame_tick && rx_class[1] && rx_sync));

   p_net_wake_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_NET && frame_tick && !deact_req && rx_class == 2'd1 && tx_info == 2'd0)
      |=> (tx_info == 2'd2 && !tx_abit));

   p_term_needs_abit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_NET && $rose(activated)) |-> $past(rx_abit));

   p_fall_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(activated) |-> $past(frame_tick));

endmodule

bind sbus_activation_ctrl sbus_activation_props #(.IS_NET(IS_NETWORK)) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_tick (frame_tick),
   .rx_class   (rx_class),
   .rx_sync    (rx_sync),
   .rx_abit    (rx_abit),
   .deact_req  (deact_req),
   .tx_info    (tx_info),
   .tx_abit    (tx_abit),
   .activated  (activated)
);

// File: tb/sbus_activation_ctrl_test.sv
`timescale 1ns/1ps
module sbus_activation_ctrl_test;
   localparam int LOSS = 3;
   localparam int TMO  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic [1:0] rx_class = 2'd0;
   logic       rx_sync = 1'b0, rx_abit = 1'b0, act_req = 1'b0, deact_req = 1'b0;
   logic [1:0] n_tx, t_tx;
   logic       n_ab, n_act, t_ab, t_act;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sbus_activation_ctrl #(.IS_NETWORK(1'b1), .LOSS_FRAMES(LOSS), .TIMEOUT_FRAMES(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_class(rx_class),
      .rx_sync(rx_sync), .rx_abit(rx_abit), .act_req(act_req), .deact_req(deact_req),
      .tx_info(n_tx), .tx_abit(n_ab), .activated(n_act));

   sbus_activation_ctrl #(.IS_NETWORK(1'b0), .LOSS_FRAMES(LOSS), .TIMEOUT_FRAMES(TMO)) uut_te (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_class(rx_class),
      .rx_sync(rx_sync), .rx_abit(rx_abit), .act_req(act_req), .deact_req(deact_req),
      .tx_info(t_tx), .tx_abit(t_ab), .activated(t_act));

   // Reference model. Network: 0 quiet, 1 offering, 2 live.
   // Terminal: 0 quiet, 1 calling, 2 answering, 3 live.
   int ns = 0, nloss = 0, ntmo = 0, nnx = 0;
   int ts = 0, tloss = 0, ttmo = 0, tnx = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns = 0; nloss = 0; ntmo = 0; ts = 0; tloss = 0; ttmo = 0;
      end else begin
         nnx = ns;
         tnx = ts;
         if (frame_tick) begin
            if (deact_req) nnx = 0;
            else if (ns == 0) begin if (act_req || rx_class == 1) nnx = 1; end
            else if (ns == 1) begin
               if (rx_class >= 2 && rx_sync) nnx = 2;
               else if (ntmo == TMO - 1) nnx = 0;
            end else if (rx_class == 0 && nloss == LOSS - 1) nnx = 0;

            if (deact_req) tnx = 0;
            else if (ts == 0) begin
               if (rx_class >= 2 && rx_sync) tnx = 2;
               else if (act_req) tnx = 1;
            end else if (ts == 1) begin
               if (rx_class >= 2 && rx_sync) tnx = 2;
               else if (ttmo == TMO - 1) tnx = 0;
            end else if (ts == 2) begin
               if (rx_class >= 2 && rx_sync && rx_abit) tnx = 3;
               else if (rx_class == 0 && tloss == LOSS - 1) tnx = 0;
               else if (ttmo == TMO - 1) tnx = 0;
            end else if (rx_class == 0 && tloss == LOSS - 1) tnx = 0;
         end
         if (ns != 2 || nnx != ns) nloss = 0;
         else if (frame_tick) nloss = (rx_class == 0) ? nloss + 1 : 0;
         if (ns != 1 || nnx != ns) ntmo = 0;
         else if (frame_tick) ntmo = ntmo + 1;
         if (ts < 2 || tnx != ts) tloss = 0;
         else if (frame_tick) tloss = (rx_class == 0) ? tloss + 1 : 0;
         if (!(ts == 1 || ts == 2) || tnx != ts) ttmo = 0;
         else if (frame_tick) ttmo = ttmo + 1;
         ns = nnx;
         ts = tnx;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // R12: outputs follow the per-frame model in every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(n_tx == ((ns == 0) ? 0 : (ns == 1) ? 2 : 3), "R12 net tx_info model", n_tx, (ns == 0) ? 0 : (ns == 1) ? 2 : 3);
         chk(n_ab == (ns == 2), "R12 net tx_abit model", n_ab, ns == 2);
         chk(n_act == (ns == 2), "R12 net activated model", n_act, ns == 2);
         chk(t_tx == ((ts == 0) ? 0 : (ts == 1) ? 1 : 3), "R12 term tx_info model", t_tx, (ts == 0) ? 0 : (ts == 1) ? 1 : 3);
         chk(t_ab == 1'b0, "R12 term tx_abit model", t_ab, 0);
         chk(t_act == (ts == 3), "R12 term activated model", t_act, ts == 3);
      end
   end

   // Called at a negedge; one strobe then three cycles with request noise.
   task automatic frame(input logic [1:0] rx, input logic s, input logic a,
                        input logic ac, input logic dc);
      rx_class = rx; rx_sync = s; rx_abit = a; act_req = ac; deact_req = dc;
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0; act_req = 1'b1; deact_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      act_req = 1'b0; deact_req = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(n_tx == 0 && !n_ab && !n_act, "R1 net reset", n_tx, 0);
      chk(t_tx == 0 && !t_ab && !t_act, "R1 term reset", t_tx, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(n_tx == 0 && t_tx == 0, "R1 after reset", n_tx + t_tx, 0);

      frame(2'd0, 0, 0, 0, 0);
      frame(2'd0, 0, 0, 0, 0);
      chk(n_tx == 0 && t_tx == 0, "R12 off-tick requests ignored", n_tx + t_tx, 0);

      frame(2'd1, 0, 0, 0, 0);
      chk(n_tx == 2 && !n_ab, "R2 net answers wake-up", n_tx, 2);
      chk(t_tx == 0, "R2 term ignores wake-up", t_tx, 0);

      frame(2'd2, 0, 0, 0, 0);
      chk(n_tx == 2 && !n_act, "R4 net waits for lock", n_tx, 2);

      frame(2'd2, 1, 0, 0, 0);
      chk(n_tx == 3 && n_ab && n_act, "R4 net activates on lock", n_tx, 3);
      chk(t_tx == 3 && !t_ab && !t_act, "R6 term answers locked frames", t_tx, 3);

      frame(2'd2, 1, 1, 0, 0);
      chk(t_act == 1, "R7 term activated on abit", t_act, 1);

      frame(2'd0, 0, 0, 0, 0);
      frame(2'd3, 1, 1, 0, 0);
      frame(2'd0, 0, 0, 0, 0);
      frame(2'd0, 0, 0, 0, 0);
      chk(n_act && t_act, "R9 broken idle run keeps link", n_act + t_act, 2);
      frame(2'd0, 0, 0, 0, 0);
      chk(!n_act && n_tx == 0, "R8 net idle run deactivates", n_tx, 0);
      chk(!t_act && t_tx == 0, "R8 term idle run deactivates", t_tx, 0);

      frame(2'd0, 0, 0, 1, 0);
      chk(n_tx == 2, "R3 net starts with announce", n_tx, 2);
      chk(t_tx == 1, "R5 term sends wake-up", t_tx, 1);
      frame(2'd0, 0, 0, 0, 0);
      frame(2'd0, 0, 0, 0, 0);
      frame(2'd0, 0, 0, 0, 0);
      chk(n_tx == 2 && t_tx == 1, "R10 attempt alive before limit", n_tx + t_tx, 3);
      frame(2'd0, 0, 0, 0, 0);
      chk(n_tx == 0, "R10 net attempt timed out", n_tx, 0);
      chk(t_tx == 0, "R10 term call timed out", t_tx, 0);

      frame(2'd2, 1, 0, 0, 0);
      chk(t_tx == 3 && n_tx == 0, "R6 term locks from idle", t_tx, 3);
      frame(2'd2, 0, 0, 0, 0);
      frame(2'd2, 0, 0, 0, 0);
      frame(2'd2, 0, 0, 0, 0);
      chk(t_tx == 3, "R10 term answer alive before limit", t_tx, 3);
      frame(2'd2, 0, 0, 0, 0);
      chk(t_tx == 0 && !t_act, "R10 term answer timed out", t_tx, 0);

      frame(2'd0, 0, 0, 1, 0);
      frame(2'd2, 1, 1, 0, 0);
      frame(2'd2, 1, 1, 0, 0);
      chk(n_act && t_act, "R11 both live before shutdown", n_act + t_act, 2);
      frame(2'd2, 1, 1, 0, 1);
      chk(n_tx == 0 && !n_act && !n_ab, "R11 net shut down", n_tx, 0);
      chk(t_tx == 0 && !t_act, "R11 term shut down", t_tx, 0);
      frame(2'd1, 0, 0, 1, 1);
      chk(n_tx == 0 && t_tx == 0, "R11 deact beats act", n_tx + t_tx, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule